// File: doc/BRIEF.md
# Reset Cause Status Register

This block remembers why the chip was last reset. It watches a power-on indication and four digital reset request lines: the external reset pin, the watchdog, brown-out detection and a software system reset. Each cause has a status bit that stays set until software clears it. Boot code reads the status word to find the cause, then writes ones to the bits it has handled. The bits it did not clear stay set, so a cause that is not acknowledged is still visible after later resets.

The status bits can be preset only by power-on. A watchdog, brown-out, pin or software reset adds its own bit and leaves the others as they were. Any request line that is still high once power-on ends is recorded as a cause of its own. The same block merges all requests into one reset line and stretches that line for a fixed number of cycles after the last request drops.

Top module: `rst_cause_reg`

## Requirements
- R1: The status word has this layout: bit 0 is power-on, bit 1 is the external pin, bit 2 is the watchdog, bit 3 is brown-out and bit 4 is software reset. Bits 31:5 always read as zero.
- R2: On a cycle with `wr_en_i` high, each write-data bit at 1 clears the status bit at the same position. Each write-data bit at 0 leaves its status bit unchanged.
- R3: While `por_i` is high, the status word is loaded every cycle with 0x00000003 (power-on and external pin bits set, the rest clear). It reads 0x00000003 on the cycle after `por_i` is sampled high.
- R4: A request line that is still high on the first cycle after `por_i` falls sets its status bit. `src_req_i` bit k maps to status bit k+1.
- R5: A request on `src_req_i` bit k sets only status bit k+1, on the following cycle. Bits that were already set stay set. No request line ever clears a status bit or sets bit 0.
- R6: If a request and a clearing write hit the same bit in the same cycle, the bit is set afterwards.
- R7: `rst_o` is high, without delay, during any cycle in which `por_i` or any `src_req_i` bit is high.
- R8: After the last request (including `por_i`) has been sampled low, `rst_o` stays high for exactly 4 more cycles and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset indication, active high, sampled synchronously |
| src_req_i | input | 4 | Reset requests: bit 0 pin, bit 1 watchdog, bit 2 brown-out, bit 3 software |
| wr_en_i | input | 1 | Write strobe for the status register |
| wr_data_i | input | 5 | Write data; a 1 clears the matching status bit |
| status_o | output | 32 | Status word, bits 31:5 zero |
| rst_o | output | 1 | Combined and stretched reset output |

## Verification
The bench aims at the cycle where a request and a clearing write hit the same bit. A design that lets the clear win would lose a cause that arrived while software was acknowledging an older one. It also holds a watchdog request across the fall of power-on. A design that samples causes only on an edge, or only outside power-on, would miss that cause. The bench counts the cycles of `rst_o` after single-cycle and back-to-back requests, which exposes a stretch that is off by one. Random writes mixed with sparse requests check that a later reset never wipes an earlier bit that was left uncleared.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned N_SRC    = 4;
  localparam int unsigned N_CAUSE  = N_SRC + 1;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned HOLD_CYC = 4;

  // value loaded while power-on is active: power-on and pin causes set
  function automatic logic [N_CAUSE-1:0] por_preset();
    logic [N_CAUSE-1:0] v;
    v = '0;
    v[0] = 1'b1;
    v[1] = 1'b1;
    return v;
  endfunction

  // one status bit: a set has priority over a write-one clear
  function automatic logic cause_bit_next(input logic cur, input logic set,
                                          input logic clr);
    return set | (cur & ~clr);
  endfunction

  // map request lines onto status positions (bit 0 is never set by requests)
  function automatic logic [N_CAUSE-1:0] req_to_set(input logic [N_SRC-1:0] req);
    return {req, 1'b0};
  endfunction
endpackage

// File: rtl/rcs_cause_bits.sv
module rcs_cause_bits
  import rcs_pkg::*;
(
  input  logic               clk,
  input  logic               por_i,
  input  logic [N_CAUSE-1:0] set_i,
  input  logic [N_CAUSE-1:0] clr_i,
  output logic [N_CAUSE-1:0] q_o
);
  localparam logic [N_CAUSE-1:0] PRESET = por_preset();

  for (genvar b = 0; b < N_CAUSE; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (por_i) q_o[b] <= PRESET[b];
      else       q_o[b] <= cause_bit_next(q_o[b], set_i[b], clr_i[b]);
    end
  end
endmodule

// File: rtl/rcs_rst_stretch.sv
module rcs_rst_stretch #(
  parameter int unsigned HOLD_CYC = 4,
  localparam int unsigned CNT_W = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic req_i,
  output logic rst_o
);
  localparam logic [CNT_W-1:0] HOLD_VAL = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] hold_q;
  logic             hold_live;

  always_ff @(posedge clk) begin
    if (req_i)          hold_q <= HOLD_VAL;
    else if (hold_live) hold_q <= hold_q - 1'b1;
  end

  assign hold_live = (hold_q != '0);
  assign rst_o     = req_i | hold_live;
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcs_pkg::*;
(
  input  logic               clk,
  input  logic               por_i,
  input  logic [N_SRC-1:0]   src_req_i,
  input  logic               wr_en_i,
  input  logic [N_CAUSE-1:0] wr_data_i,
  output logic [DATA_W-1:0]  status_o,
  output logic               rst_o
);
  logic [N_CAUSE-1:0] set_vec;
  logic [N_CAUSE-1:0] clr_vec;
  logic [N_CAUSE-1:0] cause_q;
  logic               any_req;

  assign set_vec = req_to_set(src_req_i);
  assign clr_vec = wr_en_i ? wr_data_i : '0;
  assign any_req = por_i | (|src_req_i);

  rcs_cause_bits u_bits (
    .clk   (clk),
    .por_i (por_i),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .q_o   (cause_q)
  );

  rcs_rst_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk   (clk),
    .req_i (any_req),
    .rst_o (rst_o)
  );

  assign status_o = {{(DATA_W-N_CAUSE){1'b0}}, cause_q};
endmodule

// File: rtl/rst_cause_reg_chk.sv
module rst_cause_reg_chk
  import rcs_pkg::*;
(
  input logic               clk,
  input logic               por_i,
  input logic [N_SRC-1:0]   src_req_i,
  input logic               wr_en_i,
  input logic [N_CAUSE-1:0] wr_data_i,
  input logic [DATA_W-1:0]  status_o,
  input logic               rst_o
);
  localparam int unsigned IW = $clog2(HOLD_CYC + 2);
  logic [IW-1:0] idle_q;
  logic          req_any;
  assign req_any = por_i | (|src_req_i);

  // cycles since any request was last sampled high, saturating
  always_ff @(posedge clk) begin
    if (req_any)                     idle_q <= '0;
    else if (idle_q <= IW'(HOLD_CYC)) idle_q <= idle_q + 1'b1;
  end

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (por_i)
    status_o[DATA_W-1:N_CAUSE] == '0);

  p_w1c_clear_r2: assert property (@(posedge clk) disable iff (por_i)
    (wr_en_i && (src_req_i == '0)) |=>
      ((status_o[N_CAUSE-1:0] & $past(wr_data_i)) == '0));

  p_hold_no_write_r2: assert property (@(posedge clk) disable iff (por_i)
    (!wr_en_i && (src_req_i == '0)) |=> $stable(status_o));

  p_por_preset_r3: assert property (@(posedge clk)
    por_i |=> (status_o == 32'h0000_0003));

  p_req_sets_r5: assert property (@(posedge clk) disable iff (por_i)
    (src_req_i != '0) |=>
      ((status_o[N_CAUSE-1:1] & $past(src_req_i)) == $past(src_req_i)));

  p_set_wins_r6: assert property (@(posedge clk) disable iff (por_i)
    (wr_en_i && (src_req_i != '0)) |=> status_o[N_CAUSE-1:1] != '0);

  p_rst_active_r7: assert property (@(posedge clk)
    req_any |-> rst_o);

  p_rst_hold_r8: assert property (@(posedge clk) disable iff (por_i)
    !req_any |-> (rst_o == (idle_q < IW'(HOLD_CYC))));
endmodule

bind rst_cause_reg rst_cause_reg_chk chk_i (
  .clk       (clk),
  .por_i     (por_i),
  .src_req_i (src_req_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .status_o  (status_o),
  .rst_o     (rst_o)
);

// File: tb/rst_cause_reg_tb_top.sv
module rst_cause_reg_tb_top;
  localparam int CLK_P = 10;
  localparam int HOLD  = 4;

  logic        clk = 1'b0;
  logic        por_i = 1'b1;
  logic [3:0]  src_req_i = '0;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_data_i = '0;
  logic [31:0] status_o;
  logic        rst_o;

  int vecs = 0;
  int miss = 0;
  bit done = 0;
  logic [4:0] exp_st = 5'h00;
  int exp_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  rst_cause_reg dut_i (
    .clk(clk), .por_i(por_i), .src_req_i(src_req_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .status_o(status_o), .rst_o(rst_o)
  );

  // expected status from the requirement text, bit by bit
  function automatic logic [4:0] ref_status(input logic [4:0] cur, input logic por,
      input logic [3:0] req, input logic we, input logic [4:0] wd);
    logic [4:0] n;
    if (por) return 5'b00011;
    for (int b = 0; b < 5; b++) begin
      if (b > 0 && req[b-1])   n[b] = 1'b1;
      else if (we && wd[b])    n[b] = 1'b0;
      else                     n[b] = cur[b];
    end
    return n;
  endfunction

  task automatic check(input string tag);
    logic exp_rst;
    exp_rst = por_i || (src_req_i != 0) || (exp_cnt > 0);
    vecs++;
    if (status_o !== {27'b0, exp_st}) begin
      miss++;
      $display("FAIL %s status actual=%h expected=%h", tag, status_o, {27'b0, exp_st});
    end
    vecs++;
    if (rst_o !== exp_rst) begin
      miss++;
      $display("FAIL %s rst actual=%b expected=%b", tag, rst_o, exp_rst);
    end
  endtask

  task automatic step(input logic por, input logic [3:0] req, input logic we,
                      input logic [4:0] wd, input string tag);
    @(negedge clk);
    por_i = por; src_req_i = req; wr_en_i = we; wr_data_i = wd;
    @(posedge clk);
    exp_st = ref_status(exp_st, por, req, we, wd);
    if (por || req != 0) exp_cnt = HOLD;
    else if (exp_cnt > 0) exp_cnt--;
    #(CLK_P/4);
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, 1'b0, 5'h00, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      miss++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // R3 R7: power-on preset and reset output during power-on
    for (int i = 0; i < 3; i++) step(1'b1, 4'h0, 1'b0, 5'h00, "R3_R7 por");
    // R4: watchdog held across power-on release is captured as bit 2
    step(1'b1, 4'b0010, 1'b0, 5'h00, "R4 por+wdt");
    step(1'b0, 4'b0010, 1'b0, 5'h00, "R4 release");
    // R8: stretch after the last request drops
    idle(6, "R8 stretch");
    // R1 R2: clear all, then zero write is a no-op
    step(1'b0, 4'h0, 1'b1, 5'h1F, "R1_R2 clear all");
    step(1'b0, 4'h0, 1'b1, 5'h00, "R2 zero write");
    // R5: software request sets only bit 4; R8 single-cycle stretch
    step(1'b0, 4'b1000, 1'b0, 5'h00, "R5 sw req");
    idle(5, "R8 single");
    // R5: brown-out keeps the uncleared software bit
    step(1'b0, 4'b0100, 1'b0, 5'h00, "R5 bod keeps");
    idle(5, "R8 after bod");
    // R6: set wins against a same-cycle clear on bit 2
    step(1'b0, 4'b0010, 1'b1, 5'h1F, "R6 set wins");
    idle(5, "R6 after");
    // R2: partial clear
    step(1'b0, 4'h0, 1'b1, 5'b00100, "R2 partial");
    // random mix of sparse requests and writes
    for (int i = 0; i < 400; i++) begin
      logic [3:0] rq;
      rq = (($urandom % 8) == 0) ? 4'(1 << ($urandom % 4)) : 4'h0;
      step(1'b0, rq, 1'(($urandom % 3) == 0), 5'($urandom), "R2_R5_R8 random");
    end
    // R3: power-on mid-run restores the preset
    step(1'b1, 4'h0, 1'b1, 5'h1F, "R3 por again");
    step(1'b0, 4'h0, 1'b0, 5'h00, "R3 after");
    idle(6, "R8 final");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule